// File: doc/BRIEF.md
# Software Gate-Control Status Register

This block is a single 8-bit status and control register on a simple register bus. A bus master addresses it with a 4-bit device-type code and a word address, and pulses either a read strobe or a write strobe for one clock cycle. On a read, the block samples a snapshot of live status: the active-low health and signal-valid outputs of the surrounding controller, whether the supply gate drives are on, and whether the controller is holding its reset asserted.

Only one bit can be changed by software: the gate-control bit. Writing it sets or clears a software gate request. The request is honored only while the external power-enable pin is low. The supply gate output is the OR of that software request and the hardware power-sequencing gate term. Writes to every other bit are discarded.

While the neighbouring nonvolatile store is in a write cycle, the register refuses any access addressed to it. It answers with a busy indication instead of an acknowledge, and its state does not change.

Top module: `scr_status_reg`

## Requirements
- R1: After reset, `gateReq`, `ackOut`, `busyOut` and `rdData` are all 0.
- R2: An access is addressed to the register when `devSel` equals 4'b1001 and `wordAddr` equals 8'h02. An addressed access with `nvBusy` low raises `ackOut` for exactly one cycle, in the cycle after the strobe.
- R3: A read that is addressed and not refused loads `rdData` in the cycle after the strobe. The loaded value has bit 7 = `healthyN`, bit 6 = `sigValidN` and bit 4 = `inReset`, each taken from the strobe cycle. `rdData` holds that value until the next accepted read.
- R4: In the value loaded by a read, bit 5 equals `gateOn` as it stood in the strobe cycle, and bits 3 to 0 are 0.
- R5: An accepted write with `pwrEnPin` low sets `gateReq` to bit 5 of `wrData` in the following cycle, whether that bit is 1 or 0.
- R6: An accepted write with `pwrEnPin` high leaves `gateReq` unchanged, and it is still acknowledged.
- R7: The bits of `wrData` other than bit 5 have no effect on `gateReq`. They also have no effect on the value of any later read.
- R8: An addressed access while `nvBusy` is high raises `busyOut`, not `ackOut`, for one cycle in the cycle after the strobe. It leaves `gateReq` and `rdData` unchanged.
- R9: An access with a non-matching device code or word address produces neither `ackOut` nor `busyOut`. It changes neither `gateReq` nor `rdData`.
- R10: `gateOn` is high in the same cycle whenever `gateReq` or `hwGateEn` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devSel | input | 4 | Device-type code of the current access |
| wordAddr | input | 8 | Word address of the current access |
| rdStb | input | 1 | One-cycle read strobe |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 8 | Write data; only bit 5 is used |
| nvBusy | input | 1 | Nonvolatile write cycle in progress |
| pwrEnPin | input | 1 | External power-enable pin; high blocks software gate writes |
| healthyN | input | 1 | Live active-low health output state |
| sigValidN | input | 1 | Live active-low signal-valid output state |
| inReset | input | 1 | Controller is holding reset asserted |
| hwGateEn | input | 1 | Hardware power-sequencing gate term |
| gateReq | output | 1 | Software gate request |
| gateOn | output | 1 | Supply gate enable (software OR hardware) |
| rdData | output | 8 | Captured read data |
| ackOut | output | 1 | Access acknowledge pulse |
| busyOut | output | 1 | Access refused pulse (nonvolatile write in progress) |

## Verification
The bench tries a gate write while `pwrEnPin` is high. A design that ignored the pin would drop the gates under a running card. It also writes with every bit except bit 5 set, so a design that let the mask slip would store status bits or set the gate request by accident. Accesses made during a nonvolatile write check that a refused access neither loads data nor changes the request; a design that got this wrong would acknowledge, or would corrupt `rdData`. Near-miss device codes and addresses check that the decode uses every bit, and reads taken with only the hardware gate term high check that bit 5 reports the combined gate state rather than the software bit alone.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W = 8;
  localparam int HEALTH_BIT = 7;
  localparam int SIGVAL_BIT = 6;
  localparam int GATE_BIT   = 5;
  localparam int RESET_BIT  = 4;

  typedef struct packed {
    logic accept;   // addressed access, store idle
    logic refuse;   // addressed access, store busy
    logic capture;  // accepted read: load snapshot
    logic loadReq;  // accepted write with power pin low
  } scrStrobes_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [DEV_W-1:0] DEV_CODE = 4'b1001,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02
) (
  input  logic [DEV_W-1:0]  devSel,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              nvBusy,
  input  logic              pwrEnPin,
  output scrStrobes_t       strobes
);
  logic devHit;
  logic addrHit;
  logic anyStb;
  logic addressed;

  always_comb begin
    devHit    = (devSel == DEV_CODE);
    addrHit   = (wordAddr == REG_ADDR);
    anyStb    = rdStb | wrStb;
    addressed = devHit & addrHit & anyStb;

    strobes.accept  = addressed & ~nvBusy;
    strobes.refuse  = addressed & nvBusy;
    strobes.capture = addressed & ~nvBusy & rdStb;
    strobes.loadReq = addressed & ~nvBusy & wrStb & ~pwrEnPin;
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  scrStrobes_t      strobes,
  input  logic             wrGateBit,
  input  logic             healthyN,
  input  logic             sigValidN,
  input  logic             inReset,
  input  logic             hwGateEn,
  output logic             gateReq,
  output logic             gateOn,
  output logic [REG_W-1:0] rdData,
  output logic             ackOut,
  output logic             busyOut
);
  logic [REG_W-1:0] snapshot;

  assign gateOn = gateReq | hwGateEn;

  always_comb begin
    snapshot = '0;
    snapshot[HEALTH_BIT] = healthyN;
    snapshot[SIGVAL_BIT] = sigValidN;
    snapshot[GATE_BIT]   = gateOn;
    snapshot[RESET_BIT]  = inReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateReq <= 1'b0;
      rdData  <= '0;
      ackOut  <= 1'b0;
      busyOut <= 1'b0;
    end else begin
      ackOut  <= strobes.accept;
      busyOut <= strobes.refuse;
      if (strobes.capture) rdData <= snapshot;
      if (strobes.loadReq) gateReq <= wrGateBit;
    end
  end
endmodule

// File: rtl/scr_status_reg.sv
module scr_status_reg
  import scr_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [DEV_W-1:0] DEV_CODE = 4'b1001,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEV_W-1:0]  devSel,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              nvBusy,
  input  logic              pwrEnPin,
  input  logic              healthyN,
  input  logic              sigValidN,
  input  logic              inReset,
  input  logic              hwGateEn,
  output logic              gateReq,
  output logic              gateOn,
  output logic [REG_W-1:0]  rdData,
  output logic              ackOut,
  output logic              busyOut
);
  scrStrobes_t strobes;
  logic unusedWrBits;

  // only the gate-control bit is writable; the rest is dropped
  assign unusedWrBits = ^{wrData[REG_W-1:GATE_BIT+1], wrData[GATE_BIT-1:0]};

  scr_ctrl #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE), .REG_ADDR(REG_ADDR)
  ) ctrl_i (
    .devSel(devSel), .wordAddr(wordAddr), .rdStb(rdStb), .wrStb(wrStb),
    .nvBusy(nvBusy), .pwrEnPin(pwrEnPin), .strobes(strobes)
  );

  scr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrGateBit(wrData[GATE_BIT]),
    .healthyN(healthyN), .sigValidN(sigValidN), .inReset(inReset),
    .hwGateEn(hwGateEn), .gateReq(gateReq), .gateOn(gateOn),
    .rdData(rdData), .ackOut(ackOut), .busyOut(busyOut)
  );
endmodule

// File: rtl/scr_status_reg_chk.sv
module scr_status_reg_chk #(
  parameter int DEV_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [DEV_W-1:0] DEV_CODE = 4'b1001,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h02
) (
  input logic              clk,
  input logic              rstN,
  input logic [DEV_W-1:0]  devSel,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              rdStb,
  input logic              wrStb,
  input logic [7:0]        wrData,
  input logic              nvBusy,
  input logic              pwrEnPin,
  input logic              gateReq,
  input logic [7:0]        rdData,
  input logic              ackOut,
  input logic              busyOut
);
  logic hitNow;
  assign hitNow = (devSel == DEV_CODE) && (wordAddr == REG_ADDR);

  a_r8_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(ackOut && busyOut));

  a_r8_refused_keeps_req: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && (rdStb || wrStb) && nvBusy) |=> ($stable(gateReq) && $stable(rdData) && busyOut));

  a_r5_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && wrStb && !nvBusy && !pwrEnPin) |=> (gateReq == $past(wrData[5]) && ackOut));

  a_r6_pin_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (hitNow && wrStb && pwrEnPin) |=> $stable(gateReq));

  a_r9_miss_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!hitNow) |=> (!ackOut && !busyOut && $stable(gateReq) && $stable(rdData)));

  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3:0] == 4'b0000);
endmodule

bind scr_status_reg scr_status_reg_chk #(
  .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE), .REG_ADDR(REG_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .devSel(devSel), .wordAddr(wordAddr),
  .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .nvBusy(nvBusy),
  .pwrEnPin(pwrEnPin), .gateReq(gateReq), .rdData(rdData),
  .ackOut(ackOut), .busyOut(busyOut)
);

// File: tb/scr_status_reg_tb_top.sv
module scr_status_reg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] devSel = '0;
  logic [7:0] wordAddr = '0;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic nvBusy = 1'b0, pwrEnPin = 1'b0;
  logic healthyN = 1'b1, sigValidN = 1'b1, inReset = 1'b0, hwGateEn = 1'b0;
  logic gateReq, gateOn, ackOut, busyOut;
  logic [7:0] rdData;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string phaseTag = "R1";

  // behavioural reference state
  bit mReq = 0, mAck = 0, mBusy = 0;
  bit [7:0] mRd = 0;

  always #10 clk = ~clk;

  scr_status_reg dut_i (
    .clk(clk), .rstN(rstN), .devSel(devSel), .wordAddr(wordAddr),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .nvBusy(nvBusy),
    .pwrEnPin(pwrEnPin), .healthyN(healthyN), .sigValidN(sigValidN),
    .inReset(inReset), .hwGateEn(hwGateEn), .gateReq(gateReq),
    .gateOn(gateOn), .rdData(rdData), .ackOut(ackOut), .busyOut(busyOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq <= 0; mAck <= 0; mBusy <= 0; mRd <= 0;
    end else begin
      bit hit;
      hit = (devSel == 4'd9) && (wordAddr == 8'd2) && (rdStb || wrStb);
      mAck  <= hit && !nvBusy;
      mBusy <= hit && nvBusy;
      if (hit && !nvBusy && rdStb)
        mRd <= {healthyN, sigValidN, (mReq | hwGateEn), inReset, 4'b0000};
      if (hit && !nvBusy && wrStb && !pwrEnPin)
        mReq <= wrData[5];
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phaseTag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    cmp("gateReq", gateReq, mReq);
    cmp("gateOn", gateOn, mReq | hwGateEn);
    cmp("ackOut", ackOut, mAck);
    cmp("busyOut", busyOut, mBusy);
    cmp("rdData", rdData, mRd);
  endtask

  // one clock: compare outputs at the falling edge, then drive the next inputs
  task automatic step(bit rd, bit wr, logic [3:0] dv, logic [7:0] ad, logic [7:0] wd);
    @(negedge clk);
    compareAll();
    rdStb = rd; wrStb = wr; devSel = dv; wordAddr = ad; wrData = wd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 4'd0, 8'd0, 8'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    phaseTag = "R1";
    cmp("reset gateReq", gateReq, 0);
    cmp("reset rdData", rdData, 0);
    cmp("reset ack", ackOut, 0);
    cmp("reset busy", busyOut, 0);
    rstN = 1'b1;
    idle(2);

    // R2 / R3: reads under several status patterns
    phaseTag = "R2_R3";
    for (int p = 0; p < 8; p++) begin
      step(0, 0, 4'd0, 8'd0, 8'd0);
      healthyN = p[0]; sigValidN = p[1]; inReset = p[2];
      step(1, 0, 4'b1001, 8'h02, 8'h00);
      idle(1);
    end

    // R5: write 1 with power pin low, read back
    phaseTag = "R5";
    pwrEnPin = 0;
    step(0, 1, 4'b1001, 8'h02, 8'h20);
    step(1, 0, 4'b1001, 8'h02, 8'h00);
    idle(2);
    cmp("R5 gateReq set", gateReq, 1);

    // R6: write 0 with pin high is refused but acked
    phaseTag = "R6";
    pwrEnPin = 1;
    step(0, 1, 4'b1001, 8'h02, 8'h00);
    idle(1);
    cmp("R6 ack", ackOut, 1);
    idle(1);
    cmp("R6 gateReq kept", gateReq, 1);
    pwrEnPin = 0;
    step(0, 1, 4'b1001, 8'h02, 8'h00);
    idle(2);
    cmp("R5 gateReq cleared", gateReq, 0);

    // R7: other bits written high do nothing
    phaseTag = "R7";
    healthyN = 0; sigValidN = 0; inReset = 0;
    step(0, 1, 4'b1001, 8'h02, 8'hDF);
    step(1, 0, 4'b1001, 8'h02, 8'h00);
    idle(2);
    cmp("R7 readback", rdData, 8'h00);

    // R4 / R10: hardware gate term alone shows in bit 5 and gateOn
    phaseTag = "R4_R10";
    hwGateEn = 1;
    step(1, 0, 4'b1001, 8'h02, 8'h00);
    idle(2);
    cmp("R4 bit5 hw", rdData, 8'h20);
    cmp("R10 gateOn", gateOn, 1);
    hwGateEn = 0;
    idle(1);
    cmp("R10 gateOn off", gateOn, 0);

    // R8: refused accesses during nonvolatile write
    phaseTag = "R8";
    healthyN = 1; sigValidN = 1;
    nvBusy = 1;
    step(0, 1, 4'b1001, 8'h02, 8'h20);
    step(1, 0, 4'b1001, 8'h02, 8'h00);
    cmp("R8 busy", busyOut, 1);
    cmp("R8 no ack", ackOut, 0);
    idle(2);
    cmp("R8 gateReq kept", gateReq, 0);
    cmp("R8 rdData kept", rdData, 8'h20);
    nvBusy = 0;

    // R9: near-miss device codes and addresses
    phaseTag = "R9";
    for (int b = 0; b < 4; b++) step(0, 1, 4'b1001 ^ (4'b1 << b), 8'h02, 8'h20);
    for (int b = 0; b < 8; b++) step(1, 0, 4'b1001, 8'h02 ^ (8'b1 << b), 8'h00);
    idle(2);
    cmp("R9 gateReq kept", gateReq, 0);
    cmp("R9 rdData kept", rdData, 8'h20);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule